// File: doc/BRIEF.md
# Host Controller Command Register with Interrupt Pacing

This block is the 32-bit command word of a USB-style host controller, together with the logic that the word governs. Software writes it over a single-cycle register write port and reads it back at any time. The word carries the asynchronous schedule enable, the park-mode enable and count, a write-one doorbell for asynchronous advance, a self-clearing light reset, and an interrupt threshold that limits how often the host interrupt may fire.

Events from the rest of the controller (a vector of pending-event flags, plus the doorbell event) collect in a sticky pending flag. The block counts micro-frame ticks. When a run of ticks equal to the programmed threshold completes, it delivers at most one interrupt pulse for everything that collected. The light reset returns the control fields to their defaults and clears the pacing state. It stays visible as busy until a completion strobe arrives or a fixed number of clocks has passed.

Top module: `hc_cmd_reg`

## Requirements
- R1: After reset the register reads 0008_0000h. Bits 31:24, 15:12, 10 and 4:0 always read 0.
- R2: A write places bits 23:16 into the threshold field only when the value is 01h, 02h, 04h, 08h, 10h, 20h or 40h. Any other value, 00h included, leaves the previous threshold in place.
- R3: Bit 5 holds the asynchronous schedule enable and drives `async_sched_en`. Bit 11 holds the park enable and drives `park_en`. Bits 9:8 hold the park count and drive `park_cnt`. Each is loaded by a write in which bit 7 is 0, and is visible on the next cycle.
- R4: Writing 1 to bit 6 sets the doorbell, and writing 0 to it has no effect. A cycle with `async_adv` high while the doorbell is set clears the doorbell and adds one event to the pending flag.
- R5: `host_irq` is high for one cycle. It rises the clock after a sampled `uframe_tick` that completes an interval, and only if an event was pending before that tick. The pending flag is then cleared.
- R6: An interval is a run of ticks equal to the threshold value. The tick counter restarts at every interval boundary, whether or not an interrupt was delivered.
- R7: Writing 1 to bit 7 while idle starts a light reset, and the rest of that write is ignored. Bit 7 reads 1 until a cycle with `lreset_done` high, or for at most 16 clocks, and then reads 0.
- R8: While bit 7 reads 1, several things hold. The threshold returns to 08h, and the park and schedule-enable fields return to 0. Writes are ignored. The doorbell and the pending flag are cleared. The tick counter restarts from zero, and `host_irq` stays low.
- R9: Events that arrive on any of the flags, in any number of cycles within one interval, produce a single interrupt at the end of that interval. Events that arrive in the boundary cycle wait for the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current command word |
| uframe_tick | input | 1 | One-cycle micro-frame boundary tick |
| async_adv | input | 1 | Asynchronous schedule advanced |
| evt_pending | input | EVT_W | Interrupt-worthy event flags |
| lreset_done | input | 1 | Light reset completion strobe |
| host_irq | output | 1 | Paced host interrupt pulse |
| async_sched_en | output | 1 | Asynchronous schedule enable |
| park_en | output | 1 | Park mode enable |
| park_cnt | output | 2 | Park transaction count |

## Verification
The bench builds the block with its defaults: three event flags, a 16-clock light-reset timeout with the timeout variant chosen, and thresholds up to 64 ticks. Ticks can come every cycle, so even the 64-tick interval and a full timeout fit into a short run. This lets random writes of legal and illegal threshold codes meet boundaries, doorbell advances and both ways of ending a light reset. The behavioural model tracks every field and the interrupt on each clock.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;

   localparam int ITC_W        = 8;
   localparam int ITC_LSB      = 16;
   localparam int PARK_EN_BIT  = 11;
   localparam int PARK_CNT_LSB = 8;
   localparam int LRST_BIT     = 7;
   localparam int DOOR_BIT     = 6;
   localparam int ASE_BIT      = 5;

   localparam logic [ITC_W-1:0] ITC_DEFAULT = 8'h08;

   typedef struct packed {
      logic [ITC_W-1:0] itc;
      logic             park_en;
      logic [1:0]       park_cnt;
      logic             ase;
   } ctl_t;

   localparam ctl_t CTL_DEFAULT = '{itc: ITC_DEFAULT, park_en: 1'b0,
                                    park_cnt: 2'b00, ase: 1'b0};

   // A threshold code is legal when it is a single power of two no larger
   // than 2**max_log2.
   function automatic logic itc_code_ok(input logic [ITC_W-1:0] code,
                                        input int max_log2);
      logic ok;
      ok = 1'b0;
      for (int i = 0; i < ITC_W; i++) begin
         if ((i <= max_log2) && (code == ITC_W'(1 << i))) ok = 1'b1;
      end
      return ok;
   endfunction

endpackage

// File: rtl/hc_lrst_seq.sv
module hc_lrst_seq #(
   parameter int LRST_CYCLES = 16,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);

   logic timeout_hit;

   generate
      if (USE_TIMEOUT) begin : g_timeout
         localparam int CW = $clog2(LRST_CYCLES + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !busy) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end

         assign timeout_hit = (cnt == CW'(LRST_CYCLES - 1));
      end else begin : g_no_timeout
         assign timeout_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (!busy) begin
         busy <= start;
      end else if (done || timeout_hit) begin
         busy <= 1'b0;
      end
   end

endmodule

// File: rtl/hc_cmd_fields.sv
module hc_cmd_fields
   import hc_cmd_pkg::*;
#(
   parameter int MAX_ITC_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [ITC_W-1:0] wr_itc,
   input  logic             wr_park_en,
   input  logic [1:0]       wr_park_cnt,
   input  logic             wr_lrst,
   input  logic             wr_door,
   input  logic             wr_ase,
   input  logic             lrst_busy,
   input  logic             async_adv,
   output ctl_t             ctl,
   output logic             door,
   output logic             door_evt
);

   logic field_wr;
   logic itc_ok;

   assign field_wr = wr && !wr_lrst && !lrst_busy;
   assign itc_ok   = itc_code_ok(wr_itc, MAX_ITC_LOG2);

   always_ff @(posedge clk) begin
      if (!rst_n || lrst_busy) begin
         ctl <= CTL_DEFAULT;
      end else if (field_wr) begin
         ctl.ase      <= wr_ase;
         ctl.park_en  <= wr_park_en;
         ctl.park_cnt <= wr_park_cnt;
         if (itc_ok) ctl.itc <= wr_itc;
      end
   end

   // Doorbell: write-one sets, advance clears; a ring in the same cycle as
   // an advance survives as a fresh request.
   always_ff @(posedge clk) begin
      if (!rst_n || lrst_busy) begin
         door <= 1'b0;
      end else begin
         door <= (door && !async_adv) || (field_wr && wr_door);
      end
   end

   assign door_evt = door && async_adv && !lrst_busy;

endmodule

// File: rtl/hc_irq_pacer.sv
module hc_irq_pacer
   import hc_cmd_pkg::*;
#(
   parameter int EVT_W        = 3,
   parameter int MAX_ITC_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic [ITC_W-1:0] itc,
   input  logic [EVT_W-1:0] evt,
   input  logic             door_evt,
   output logic             irq
);

   localparam int CNT_W = MAX_ITC_LOG2;

   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic             new_evt;
   logic             boundary;
   logic [ITC_W-1:0] cnt_next;

   assign new_evt  = (|evt) || door_evt;
   assign cnt_next = ITC_W'(cnt) + ITC_W'(1);
   assign boundary = tick && (cnt_next >= itc);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt  <= '0;
         pend <= 1'b0;
         irq  <= 1'b0;
      end else begin
         irq  <= boundary && pend;
         pend <= (pend && !boundary) || new_evt;
         if (tick) begin
            cnt <= boundary ? '0 : cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
   import hc_cmd_pkg::*;
#(
   parameter int EVT_W        = 3,
   parameter int MAX_ITC_LOG2 = 6,
   parameter int LRST_CYCLES  = 16,
   parameter bit USE_TIMEOUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             uframe_tick,
   input  logic             async_adv,
   input  logic [EVT_W-1:0] evt_pending,
   input  logic             lreset_done,
   output logic             host_irq,
   output logic             async_sched_en,
   output logic             park_en,
   output logic [1:0]       park_cnt
);

   generate
      if (EVT_W < 1) begin : g_bad_evt
         $error("hc_cmd_reg: EVT_W must be at least 1");
      end
      if (MAX_ITC_LOG2 < 3 || MAX_ITC_LOG2 > ITC_W - 1) begin : g_bad_itc
         $error("hc_cmd_reg: MAX_ITC_LOG2 must lie in 3..7");
      end
      if (LRST_CYCLES < 2) begin : g_bad_lrst
         $error("hc_cmd_reg: LRST_CYCLES must be at least 2");
      end
   endgenerate

   ctl_t ctl;
   logic lrst_busy;
   logic lrst_start;
   logic door;
   logic door_evt;
   logic wdata_unused;

   assign wdata_unused = ^{reg_wdata[31:24], reg_wdata[15:12],
                           reg_wdata[10], reg_wdata[4:0]};

   assign lrst_start = reg_wr && reg_wdata[LRST_BIT] && !lrst_busy;

   hc_lrst_seq #(
      .LRST_CYCLES (LRST_CYCLES),
      .USE_TIMEOUT (USE_TIMEOUT)
   ) u_lrst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (lrst_start),
      .done  (lreset_done),
      .busy  (lrst_busy)
   );

   hc_cmd_fields #(
      .MAX_ITC_LOG2 (MAX_ITC_LOG2)
   ) u_fields (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (reg_wr),
      .wr_itc      (reg_wdata[ITC_LSB +: ITC_W]),
      .wr_park_en  (reg_wdata[PARK_EN_BIT]),
      .wr_park_cnt (reg_wdata[PARK_CNT_LSB +: 2]),
      .wr_lrst     (reg_wdata[LRST_BIT]),
      .wr_door     (reg_wdata[DOOR_BIT]),
      .wr_ase      (reg_wdata[ASE_BIT]),
      .lrst_busy   (lrst_busy),
      .async_adv   (async_adv),
      .ctl         (ctl),
      .door        (door),
      .door_evt    (door_evt)
   );

   hc_irq_pacer #(
      .EVT_W        (EVT_W),
      .MAX_ITC_LOG2 (MAX_ITC_LOG2)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (lrst_busy),
      .tick     (uframe_tick),
      .itc      (ctl.itc),
      .evt      (evt_pending),
      .door_evt (door_evt),
      .irq      (host_irq)
   );

   always_comb begin
      reg_rdata                          = '0;
      reg_rdata[ITC_LSB +: ITC_W]        = ctl.itc;
      reg_rdata[PARK_EN_BIT]             = ctl.park_en;
      reg_rdata[PARK_CNT_LSB +: 2]       = ctl.park_cnt;
      reg_rdata[LRST_BIT]                = lrst_busy;
      reg_rdata[DOOR_BIT]                = door;
      reg_rdata[ASE_BIT]                 = ctl.ase;
   end

   assign async_sched_en = ctl.ase;
   assign park_en        = ctl.park_en;
   assign park_cnt       = ctl.park_cnt;

endmodule

// File: rtl/hc_cmd_reg_chk.sv
module hc_cmd_reg_chk #(
   parameter int LRST_CYCLES = 16,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        wr_door,
   input logic        wr_lrst,
   input logic [31:0] reg_rdata,
   input logic        uframe_tick,
   input logic        async_adv,
   input logic        host_irq
);

   logic [31:0] busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n || !reg_rdata[7]) busy_len <= '0;
      else                         busy_len <= busy_len + 32'd1;
   end

   p_itc_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(reg_rdata[23:16]) && (reg_rdata[23:16] <= 8'h40));

   p_door_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[6] && async_adv && !reg_rdata[7] && !(reg_wr && wr_door && !wr_lrst))
      |=> !reg_rdata[6]);

   p_irq_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> $past(uframe_tick));

   p_lrst_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      USE_TIMEOUT |-> (busy_len <= 32'(LRST_CYCLES)));

   p_lrst_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] |=> ((reg_rdata[23:16] == 8'h08) && !reg_rdata[11]
                        && (reg_rdata[9:8] == 2'b00) && !reg_rdata[6] && !reg_rdata[5]));

   p_no_irq_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7] && $past(reg_rdata[7])) |-> !host_irq);

endmodule

bind hc_cmd_reg hc_cmd_reg_chk #(
   .LRST_CYCLES (LRST_CYCLES),
   .USE_TIMEOUT (USE_TIMEOUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .wr_door     (reg_wdata[6]),
   .wr_lrst     (reg_wdata[7]),
   .reg_rdata   (reg_rdata),
   .uframe_tick (uframe_tick),
   .async_adv   (async_adv),
   .host_irq    (host_irq)
);

// File: tb/hc_cmd_reg_bench.sv
module hc_cmd_reg_bench;

   localparam int CLK_PERIOD = 10;
   localparam int EVT_W      = 3;
   localparam int LRST_N     = 16;
   localparam logic [31:0] RSV_MASK = 32'hFF00_F41F;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic             uframe_tick = 1'b0;
   logic             async_adv = 1'b0;
   logic [EVT_W-1:0] evt_pending = '0;
   logic             lreset_done = 1'b0;
   logic             host_irq;
   logic             async_sched_en;
   logic             park_en;
   logic [1:0]       park_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   hc_cmd_reg #(
      .EVT_W        (EVT_W),
      .MAX_ITC_LOG2 (6),
      .LRST_CYCLES  (LRST_N),
      .USE_TIMEOUT  (1'b1)
   ) u_hc_cmd_reg (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_wr         (reg_wr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .uframe_tick    (uframe_tick),
      .async_adv      (async_adv),
      .evt_pending    (evt_pending),
      .lreset_done    (lreset_done),
      .host_irq       (host_irq),
      .async_sched_en (async_sched_en),
      .park_en        (park_en),
      .park_cnt       (park_cnt)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_on = 1'b0;
   int cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   int m_itc = 8, m_ase = 0, m_pen = 0, m_pcnt = 0;
   int m_lrst = 0, m_lcnt = 0, m_door = 0;
   int m_ticks = 0, m_pend = 0, m_irq = 0;

   function automatic bit legal_code(int v);
      return v == 1 || v == 2 || v == 4 || v == 8 || v == 16 || v == 32 || v == 64;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_itc = 8; m_ase = 0; m_pen = 0; m_pcnt = 0;
         m_lrst = 0; m_lcnt = 0; m_door = 0;
         m_ticks = 0; m_pend = 0; m_irq = 0;
      end else begin
         int busy;
         bit fw;
         busy = m_lrst;
         fw = reg_wr && !reg_wdata[7] && busy == 0;
         if (busy != 0) begin
            m_irq = 0; m_ticks = 0; m_pend = 0;
         end else begin
            bit bnd, dev, ne;
            bnd = uframe_tick && (m_ticks + 1 >= m_itc);
            dev = (m_door != 0) && async_adv;
            ne  = (evt_pending != 0) || dev;
            m_irq = (bnd && m_pend != 0) ? 1 : 0;
            if (uframe_tick) m_ticks = bnd ? 0 : m_ticks + 1;
            m_pend = ((m_pend != 0 && !bnd) || ne) ? 1 : 0;
         end
         if (busy != 0) m_door = 0;
         else m_door = ((m_door != 0 && !async_adv) || (fw && reg_wdata[6])) ? 1 : 0;
         if (busy != 0) begin
            m_itc = 8; m_ase = 0; m_pen = 0; m_pcnt = 0;
         end else if (fw) begin
            m_ase  = int'(reg_wdata[5]);
            m_pen  = int'(reg_wdata[11]);
            m_pcnt = int'(reg_wdata[9:8]);
            if (legal_code(int'(reg_wdata[23:16]))) m_itc = int'(reg_wdata[23:16]);
         end
         if (busy == 0) begin
            if (reg_wr && reg_wdata[7]) begin m_lrst = 1; m_lcnt = 0; end
         end else if (lreset_done || m_lcnt == LRST_N - 1) begin
            m_lrst = 0;
         end else begin
            m_lcnt++;
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R1 reserved bits", reg_rdata & RSV_MASK, 32'h0);
         chk("R2 threshold field", {24'h0, reg_rdata[23:16]}, 32'(m_itc));
         chk("R3 ase", {31'h0, async_sched_en}, 32'(m_ase));
         chk("R3 park enable", {31'h0, park_en}, 32'(m_pen));
         chk("R3 park count", {30'h0, park_cnt}, 32'(m_pcnt));
         chk("R3 readback", {20'h0, reg_rdata[11], 1'b0, reg_rdata[9:8], 2'b0, reg_rdata[5], 5'h0},
             32'((m_pen << 11) | (m_pcnt << 8) | (m_ase << 5)));
         chk("R4 doorbell", {31'h0, reg_rdata[6]}, 32'(m_door));
         chk("R5 host_irq", {31'h0, host_irq}, 32'(m_irq));
         chk("R7 light reset busy", {31'h0, reg_rdata[7]}, 32'(m_lrst));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [31:0] d);
      reg_wr = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic ticks_to_irq(output int n);
      n = 0;
      uframe_tick = 1'b1;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         n++;
         if (host_irq) break;
      end
      uframe_tick = 1'b0;
   endtask

   initial begin
      int n;
      int irqs;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      chk("R1 reset value", reg_rdata, 32'h0008_0000);

      // R3: control fields load and drive ports
      wr(32'h0002_0B20);
      chk("R3 written word", reg_rdata, 32'h0002_0B20);
      chk("R3 port values", {29'h0, async_sched_en, park_en, park_cnt[1]}, 32'h7);

      // R2: illegal codes keep the last legal one
      wr(32'h0003_0020);
      chk("R2 code 03h kept 02h", reg_rdata, 32'h0002_0020);
      wr(32'h0000_0020);
      chk("R2 code 00h kept 02h", reg_rdata, 32'h0002_0020);
      wr(32'h0080_0020);
      chk("R2 code 80h kept 02h", reg_rdata, 32'h0002_0020);
      wr(32'h0040_0020);
      chk("R2 code 40h taken", reg_rdata, 32'h0040_0020);

      // R4: doorbell set, zero write ignored, cleared by advance
      wr(32'h0008_0040);
      chk("R4 doorbell set", {31'h0, reg_rdata[6]}, 32'h1);
      wr(32'h0008_0000);
      chk("R4 zero write no effect", {31'h0, reg_rdata[6]}, 32'h1);
      async_adv = 1'b1;
      @(negedge clk);
      async_adv = 1'b0;
      chk("R4 cleared by advance", {31'h0, reg_rdata[6]}, 32'h0);

      // R7: timeout-bounded light reset, R8 defaults
      wr(32'h0004_0B20);
      wr(32'h0001_0BA0);
      chk("R7 busy with old fields", reg_rdata, 32'h0004_0BA0);
      n = 1;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (k == 0) chk("R8 defaults during reset", reg_rdata, 32'h0008_0080);
         if (!reg_rdata[7]) break;
         n++;
      end
      chk("R7 busy length", 32'(n), 32'(LRST_N));

      // R7/R8: write ignored while busy, early finish by done strobe
      wr(32'h0000_0080);
      wr(32'h0001_0B20);
      chk("R8 write ignored while busy", reg_rdata, 32'h0008_0080);
      lreset_done = 1'b1;
      @(negedge clk);
      lreset_done = 1'b0;
      chk("R7 done strobe ends reset", reg_rdata, 32'h0008_0000);

      // R6/R9: interval of 4 ticks, counter restarted by the reset above
      wr(32'h0004_0000);
      evt_pending = 3'b001; @(negedge clk);
      evt_pending = 3'b100; @(negedge clk);
      evt_pending = 3'b010; @(negedge clk);
      evt_pending = '0;
      ticks_to_irq(n);
      chk("R9 one irq after 4 ticks for 3 events", 32'(n), 32'd4);
      irqs = 0;
      uframe_tick = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (host_irq) irqs++;
      end
      uframe_tick = 1'b0;
      chk("R5 no irq without pending events", 32'(irqs), 32'd0);
      evt_pending = 3'b010; @(negedge clk);
      evt_pending = '0;
      ticks_to_irq(n);
      chk("R6 counter reloaded at empty boundary", 32'(n), 32'd4);

      // random phase, model compared every clock
      for (int k = 0; k < 6000; k++) begin
         uframe_tick = ($urandom_range(0, 1) == 0);
         evt_pending = ($urandom_range(0, 7) == 0) ? EVT_W'($urandom) : '0;
         async_adv   = ($urandom_range(0, 7) == 0);
         lreset_done = ($urandom_range(0, 19) == 0);
         reg_wr      = ($urandom_range(0, 5) == 0);
         begin
            logic [7:0] code;
            logic [15:0] low;
            code = ($urandom_range(0, 2) != 0) ? 8'(1 << $urandom_range(0, 6)) : 8'($urandom);
            low  = 16'($urandom);
            low[7] = ($urandom_range(0, 15) == 0);
            reg_wdata = {8'($urandom), code, low};
         end
         @(negedge clk);
      end
      reg_wr = 1'b0;
      uframe_tick = 1'b0;
      evt_pending = '0;
      async_adv = 1'b0;
      lreset_done = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule